// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the clock-line timing for an I2C controller. A 7-bit period value sets a prescale of 2·(1+T) system clocks per timing unit. Every SCL period is six units low followed by four units high, so one period lasts 20·(1+T) system clocks. Along with the line level the block emits single-cycle strobes: one at the start of the low phase, one at the start of the high phase, one midway through the low phase (where a data line may change) and one midway through the high phase (where a data line may be sampled).

The period value is loaded through a one-word write port. Bit 7 of the word is a guard: the write lands only when that bit is 0. A newly written value waits for the current SCL period to finish, so no phase is ever cut short. While the enable input is low the line rests high and no strobes are issued. The low phase begins on the cycle after enable is first seen high.

Top module: `scl_phase_gen`

## Requirements
- R1: With period value T in force, successive low-phase-start strobes are exactly 20·(1+T) system clocks apart.
- R2: Each period holds `scl_out` at 0 for 12·(1+T) clocks and then at 1 for 8·(1+T) clocks.
- R3: A write (`wr_en`=1 with `wr_data[7]`=0) stores `wr_data[6:0]` as the period value. The value after reset is 1.
- R4: A write with `wr_data[7]`=1 leaves the stored period value unchanged, both as an isolated write and as one made during a period.
- R5: A timing unit is 2·(1+T) clocks. The mid-low strobe comes 3 units after the low-start strobe, the high-start strobe 6 units after it, and the mid-high strobe 8 units after it.
- R6: A value written during a period leaves that period at its old length. The new value governs from the next period onward.
- R7: While `enable` is 0, `scl_out` is 1 and all four strobes are 0. When `enable` is sampled 1 at a clock edge after being 0, `scl_out` is 0 and `low_start` is 1 in the following cycle.
- R8: Each period contains exactly one pulse of each strobe, and no two strobes are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator when high |
| wr_en | input | 1 | Write strobe for the period word |
| wr_data | input | 8 | [6:0] period value, [7] guard (must be 0) |
| scl_out | output | 1 | Clock line level |
| low_start | output | 1 | First cycle of the low phase |
| mid_low | output | 1 | Middle of the low phase (data-change point) |
| high_start | output | 1 | First cycle of the high phase |
| mid_high | output | 1 | Middle of the high phase (sample point) |

## Verification
The assertions assume that `enable` changes only at clock edges and that writes arrive as one-cycle pulses. They also assume that a write and the rising edge of `enable` never fall in the same cycle, since that ordering is not defined here. The stimulus drives every input on the falling clock edge and holds `wr_en` for exactly one cycle. It sweeps the period value over a contiguous low range plus the mid and maximum points. Writes are placed both at idle points and inside a running period, with the guard bit both clear and set.

// File: rtl/scl_timing_pkg.sv
// Package: shared strobe encoding and unit-position helper for the SCL
// period generator. Assumes low and high phase lengths are even.
package scl_timing_pkg;

    // Order of the strobe vector produced by the phase counter.
    typedef enum logic [1:0] {
        STB_LOW_START  = 2'd0,
        STB_MID_LOW    = 2'd1,
        STB_HIGH_START = 2'd2,
        STB_MID_HIGH   = 2'd3
    } strobe_e;

    localparam int NUM_STROBES = 4;

    // Unit index at which a strobe fires, given the phase lengths.
    function automatic int strobe_unit(input int which, input int low_u, input int high_u);
        case (which)
            0:       return 0;
            1:       return low_u / 2;
            2:       return low_u;
            default: return low_u + high_u / 2;
        endcase
    endfunction

endpackage

// File: rtl/scl_tpr_reg.sv
// Module: scl_tpr_reg
// Holds the programmed period value and the value in force. A write lands
// only when the guard bit (top bit of the word) is 0. The value in force is
// copied from the programmed one while the generator is stopped and at each
// period boundary. Assumes wr_en is a single-cycle pulse.
module scl_tpr_reg #(
    parameter int TPR_W   = 7,
    parameter int TPR_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             boundary,
    input  logic             wr_en,
    input  logic [TPR_W:0]   wr_data,
    output logic [TPR_W-1:0] tpr_act
);
    localparam int GUARD_BIT = TPR_W;

    logic [TPR_W-1:0] tpr_prog;

    // Programmed value: guarded write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tpr_prog <= TPR_W'(TPR_RST);
        else if (wr_en && !wr_data[GUARD_BIT])
            tpr_prog <= wr_data[TPR_W-1:0];
    end

    // Value in force: follows programmed value only when stopped or at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tpr_act <= TPR_W'(TPR_RST);
        else if (!run || boundary)
            tpr_act <= tpr_prog;
    end

    p_guard_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[GUARD_BIT]) |=> $stable(tpr_prog));

    p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !boundary) |=> $stable(tpr_act));

endmodule

// File: rtl/scl_prescaler.sv
// Module: scl_prescaler
// Divides the system clock by 2*(1+T) to make one timing-unit tick.
// Assumes tpr only changes on the cycle its tick is issued or while stopped.
module scl_prescaler #(
    parameter int TPR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TPR_W-1:0] tpr,
    output logic             unit_tick,
    output logic             unit_first
);
    localparam int CNT_W = TPR_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] div;

    // Clocks per unit minus one is the terminal count.
    always_comb begin
        div        = (CNT_W'(tpr) + CNT_W'(1)) << 1;
        unit_tick  = run && (cnt == div - CNT_W'(1));
        unit_first = run && (cnt == '0);
    end

    // Unit counter: clears when stopped and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || unit_tick)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));

endmodule

// File: rtl/scl_phase_ctr.sv
// Module: scl_phase_ctr
// Counts timing units through one SCL period (low units then high units),
// reports the low level, the period boundary and four positional strobes.
// Assumes LOW_UNITS and HIGH_UNITS are even and at least 2.
module scl_phase_ctr
    import scl_timing_pkg::*;
#(
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   unit_tick,
    input  logic                   unit_first,
    output logic                   scl_low,
    output logic                   boundary,
    output logic [NUM_STROBES-1:0] strobes
);
    localparam int TOTAL = LOW_UNITS + HIGH_UNITS;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

    logic [IDX_W-1:0] idx;

    // Unit index within the period: wraps to the low phase after the last high unit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            idx <= '0;
        else if (unit_tick)
            idx <= (idx == LAST) ? '0 : idx + IDX_W'(1);
    end

    // Line level and period boundary from the unit index.
    always_comb begin
        scl_low  = run && (idx < IDX_W'(LOW_UNITS));
        boundary = unit_tick && (idx == LAST);
    end

    // One decoder per strobe, positioned by the package helper.
    for (genvar k = 0; k < NUM_STROBES; k++) begin : g_strobe
        localparam logic [IDX_W-1:0] POS = IDX_W'(strobe_unit(k, LOW_UNITS, HIGH_UNITS));
        assign strobes[k] = unit_first && (idx == POS);
    end

    p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);

endmodule

// File: rtl/scl_phase_gen.sv
// Module: scl_phase_gen (top)
// SCL period generator: guarded period register, unit prescaler and phase
// counter. Assumes enable and wr_en are synchronous to clk.
module scl_phase_gen
    import scl_timing_pkg::*;
#(
    parameter int TPR_W      = 7,
    parameter int TPR_RST    = 1,
    parameter int LOW_UNITS  = 6,
    parameter int HIGH_UNITS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           wr_en,
    input  logic [TPR_W:0] wr_data,
    output logic           scl_out,
    output logic           low_start,
    output logic           mid_low,
    output logic           high_start,
    output logic           mid_high
);
    logic                   run_q;
    logic [TPR_W-1:0]       tpr_act;
    logic                   unit_tick;
    logic                   unit_first;
    logic                   scl_low;
    logic                   boundary;
    logic [NUM_STROBES-1:0] strobes;

    // Registered enable: the period starts one cycle after enable is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else
            run_q <= enable;
    end

    scl_tpr_reg #(.TPR_W(TPR_W), .TPR_RST(TPR_RST)) u_tpr (
        .clk(clk), .rst_n(rst_n), .run(run_q), .boundary(boundary),
        .wr_en(wr_en), .wr_data(wr_data), .tpr_act(tpr_act)
    );

    scl_prescaler #(.TPR_W(TPR_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tpr(tpr_act),
        .unit_tick(unit_tick), .unit_first(unit_first)
    );

    scl_phase_ctr #(.LOW_UNITS(LOW_UNITS), .HIGH_UNITS(HIGH_UNITS)) u_ph (
        .clk(clk), .rst_n(rst_n), .run(run_q), .unit_tick(unit_tick),
        .unit_first(unit_first), .scl_low(scl_low), .boundary(boundary),
        .strobes(strobes)
    );

    // Output mapping: line idles high when stopped.
    always_comb begin
        scl_out    = !scl_low;
        low_start  = strobes[STB_LOW_START];
        mid_low    = strobes[STB_MID_LOW];
        high_start = strobes[STB_HIGH_START];
        mid_high   = strobes[STB_MID_HIGH];
    end

    p_fall_marks_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_out) |-> low_start);

    p_rise_marks_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_out) && run_q) |-> high_start);

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !(low_start || mid_low || high_start || mid_high));

endmodule

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       scl_out, low_start, mid_low, high_start, mid_high;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_phase_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_data(wr_data), .scl_out(scl_out), .low_start(low_start),
        .mid_low(mid_low), .high_start(high_start), .mid_high(mid_high)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [7:0] w);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    // Wait for a low-start strobe, then measure one full period.
    // If wr_at >= 0, issue a write of wr_word that many cycles into the period.
    task automatic measure(input int t_exp, input int wr_at, input logic [7:0] wr_word, input string tag);
        int unit = 2 * (1 + t_exp);
        int n = 0, lows = 0, ml = 0, hs = 0, mh = 0, ml_off = -1, hs_off = -1, mh_off = -1;
        bit found = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (low_start) begin found = 1'b1; break; end
        end
        chk(found, {tag, " R1 low_start seen"}, found, 1);
        if (scl_out == 1'b0) lows = 1;
        for (int i = 0; i < 6000; i++) begin
            if (n == wr_at) begin wr_en = 1'b1; wr_data = wr_word; end
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0;
            n++;
            if (low_start) break;
            if (scl_out == 1'b0) lows++;
            if (mid_low)    begin ml++; ml_off = n; end
            if (high_start) begin hs++; hs_off = n; end
            if (mid_high)   begin mh++; mh_off = n; end
        end
        chk(n == 10 * unit, {tag, " R1 period"}, n, 10 * unit);
        chk(lows == 6 * unit, {tag, " R2 low length"}, lows, 6 * unit);
        chk(ml == 1 && hs == 1 && mh == 1, {tag, " R8 one of each strobe"}, ml + hs + mh, 3);
        chk(ml_off == 3 * unit, {tag, " R5 mid_low offset"}, ml_off, 3 * unit);
        chk(hs_off == 6 * unit, {tag, " R5 high_start offset"}, hs_off, 6 * unit);
        chk(mh_off == 8 * unit, {tag, " R5 mid_high offset"}, mh_off, 8 * unit);
    endtask

    // Hold enable low for n cycles and confirm the line stays quiet (R7).
    task automatic idle_check(input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!scl_out || low_start || mid_low || high_start || mid_high) bad++;
        end
        chk(bad == 0, {tag, " R7 idle quiet"}, bad, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        repeat (4) @(negedge clk);
        chk(scl_out == 1'b1, "R7 reset scl", scl_out, 1);
        chk({low_start, mid_low, high_start, mid_high} == 4'b0, "R7 reset strobes",
            {low_start, mid_low, high_start, mid_high}, 0);
        rst_n = 1'b1;
        idle_check(40, "disabled");

        // Enable: low phase must begin on the next sampled cycle (R7).
        enable = 1'b1;
        @(negedge clk);
        chk(scl_out == 1'b0, "R7 scl low after enable", scl_out, 0);
        chk(low_start == 1'b1, "R7 low_start after enable", low_start, 1);

        // Reset value 1 in force (R3).
        measure(1, -1, 8'h00, "reset value R3");

        // Sweep of period values (R1 R2 R3 R5 R8).
        for (int t = 2; t <= 24; t++) begin
            write_word(8'(t));
            measure(t, -1, 8'h00, $sformatf("sweep t=%0d R3", t));
        end
        write_word(8'd64);
        measure(64, -1, 8'h00, "t=64");
        write_word(8'd127);
        measure(127, -1, 8'h00, "t=127 max");

        // Guarded write ignored (R4).
        write_word(8'd5);
        measure(5, -1, 8'h00, "t=5");
        write_word(8'h89);
        measure(5, -1, 8'h00, "guard set R4");

        // Mid-period write: current period keeps old length (R6), then new applies.
        measure(5, 7, 8'd20, "mid-period write old length R6");
        measure(20, -1, 8'h00, "new value next period R6");

        // Guarded write made inside a period changes nothing (R4).
        measure(20, 30, 8'h83, "guarded mid-period R4");
        measure(20, -1, 8'h00, "after guarded mid-period R4");

        // Disable mid-run, write while stopped, re-enable (R7 R3).
        enable = 1'b0;
        @(negedge clk);
        chk(scl_out == 1'b1, "R7 scl high after disable", scl_out, 1);
        idle_check(30, "stopped");
        write_word(8'd3);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        chk(low_start == 1'b1 && scl_out == 1'b0, "R7 restart low phase",
            {low_start, scl_out}, 2);
        measure(3, -1, 8'h00, "after restart R3");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule